// File: doc/BRIEF.md
# DSI Video-Mode Frame Timing Generator

This block produces the frame skeleton that a DSI host follows when it streams video. Every clock cycle is one lane byte clock. Within a line, the counter moves through four segments. The first is the horizontal sync, then the horizontal back porch, then the active segment that carries one pixel packet, and last the horizontal front porch. The sync and back-porch widths are programmed directly in byte clocks. The active width is derived from the packet size in pixels, at 24-bit colour (3 bytes per pixel), spread over 1 to 4 lanes. The front porch is not programmed. It fills whatever is left of the programmed total line time. Vertically, the frame runs through sync lines, back-porch lines, active lines and front-porch lines, in that order.

Downstream packet assembly consumes the per-cycle segment flags, the line and frame start strobes, and a packet-request strobe. The sync start and end strobes let the packet assembler emit either sync-event or sync-pulse packets, depending on the selected video-mode type. Both sync outputs have a programmable polarity. All configuration is sampled while reset is held and again at each frame boundary, so software may rewrite it at any time without tearing the current frame.

Top module: `dsi_vid_timing`

## Requirements
- R1: While reset is low and in the first cycle after it is released, both counters are at zero, so line_start and frame_start are 1. The configuration present on the inputs during reset governs the first frame.
- R2: Each line begins with cfg_hsa cycles of hsync and continues with cfg_hbp cycles of hbp. Exactly one of hsync, hbp, hact, hfp is 1 in every cycle.
- R3: After the back porch, hact is 1 for A = ceil(3*cfg_pkt/lanes) cycles. A cfg_lanes value of 0 counts as 1 lane, and any value above 4 counts as 4 lanes.
- R4: A line lasts max(cfg_hline, cfg_hsa+cfg_hbp+A, 1) cycles, and hfp fills the cycles after the active segment. When cfg_hline is smaller than cfg_hsa+cfg_hbp+A, hfp never occurs and line_err is 1 for the whole frame.
- R5: The frame consists of V sync lines, then cfg_vbp lines of vbp, then cfg_vact lines of vact, then cfg_vfp lines of vfp. Its length is max(total, 1) lines, exactly one vertical flag is 1 in every cycle, and the vertical flags change only at line starts.
- R6: The number of vsync lines is V = min(cfg_vsa, 15).
- R7: hsync_pin = hsync XOR cfg_pol[2] and vsync_pin = vsync XOR cfg_pol[1], so a set bit makes that sync active low.
- R8: line_start is 1 in the first cycle of every line. frame_start is 1 in the first cycle of the first line. pkt_req is 1 in the first hact cycle of every line that lies in the vact region.
- R9: hs_start is 1 in the first hsync cycle of every line, and vs_start is 1 in the first cycle of a frame whose V is greater than 0.
- R10: The mode field uses 0 for non-burst with sync pulses, 1 for non-burst with sync events, and 2 or 3 for burst. In mode 1, hs_end and vs_end stay 0. In the other modes, hs_end marks the last hsync cycle of each line and vs_end marks the last cycle of the last vsync line.
- R11: Configuration inputs are sampled only at the frame boundary, so changing them in the middle of a frame has no effect until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_hsa | input | HW | Horizontal sync width, byte clocks |
| cfg_hbp | input | HW | Horizontal back porch, byte clocks |
| cfg_hline | input | HW | Total line time, byte clocks |
| cfg_pkt | input | PW | Active packet size, pixels |
| cfg_lanes | input | 3 | Lane count (1..4, clamped) |
| cfg_vsa | input | VW | Vertical sync lines (capped at 15) |
| cfg_vbp | input | VW | Vertical back-porch lines |
| cfg_vact | input | VW | Vertical active lines |
| cfg_vfp | input | VW | Vertical front-porch lines |
| cfg_pol | input | 2 (bits 2:1) | Bit 2: hsync active low; bit 1: vsync active low |
| cfg_mode | input | 2 | Video-mode type |
| hsync | output | 1 | Horizontal sync segment |
| hbp | output | 1 | Horizontal back-porch segment |
| hact | output | 1 | Horizontal active segment |
| hfp | output | 1 | Horizontal front-porch segment |
| vsync | output | 1 | Vertical sync lines |
| vbp | output | 1 | Vertical back-porch lines |
| vact | output | 1 | Vertical active lines |
| vfp | output | 1 | Vertical front-porch lines |
| hsync_pin | output | 1 | Polarity-adjusted horizontal sync |
| vsync_pin | output | 1 | Polarity-adjusted vertical sync |
| line_start | output | 1 | First cycle of a line |
| frame_start | output | 1 | First cycle of a frame |
| pkt_req | output | 1 | Request for the line's pixel packet |
| hs_start | output | 1 | Horizontal sync begins |
| hs_end | output | 1 | Last horizontal sync cycle (pulse modes) |
| vs_start | output | 1 | Vertical sync begins |
| vs_end | output | 1 | Last vertical sync cycle (pulse modes) |
| line_err | output | 1 | Line time too short for its segments |

## Verification
Several properties are checked on every cycle by the assertions. A packet request only ever occurs inside both active regions. No front porch appears while the line time is flagged as too short. A sync row never goes past the fifteenth line. The vertical flags move only at line starts. Configuration stays frozen between frame boundaries. The counters never run past their terminal counts. Other behaviour can only be shown by the bench's sweep over lane counts, packet sizes, line times, modes and polarities, where expected values are computed arithmetically. This covers the exact segment lengths, including the ceiling division of the active width and the clamping of the lane count. It also covers the position of every strobe and the deferred take-up of configuration that changes in the middle of a frame.

// File: rtl/dvt_pkg.sv
`timescale 1ns/1ps
// Shared types for the DSI video timing generator.
package dvt_pkg;
    // Segment a counter is in: sync, back porch, active, front porch (in time order).
    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_ACT   = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;

    // Video-mode code that suppresses sync end markers.
    localparam logic [1:0] MODE_SYNC_EVENTS = 2'd1;
endpackage

// File: rtl/dvt_act_len.sv
`timescale 1ns/1ps
// dvt_act_len: converts a pixel packet size into active byte clocks.
// Assumes 3 bytes per pixel; lane codes 0 and 1 mean one lane, 4 and above
// mean four lanes. Result is ceil(3*pkt/lanes). Purely combinational.
module dvt_act_len #(
    parameter int PW = 10,
    parameter int AW = PW + 2
) (
    input  logic [PW-1:0] pkt,
    input  logic [2:0]    lanes,
    output logic [AW-1:0] act
);
    logic [AW:0] bytes3;

    // Byte count, then a ceiling divide by the clamped lane count.
    always_comb begin
        bytes3 = (AW+1)'(pkt) + ((AW+1)'(pkt) << 1);
        case (lanes)
            3'd0, 3'd1: act = bytes3[AW-1:0];
            3'd2:       act = AW'((bytes3 + (AW+1)'(1)) >> 1);
            3'd3:       act = AW'(pkt);
            default:    act = AW'((bytes3 + (AW+1)'(3)) >> 2);
        endcase
    end
endmodule

// File: rtl/dvt_shadow.sv
`timescale 1ns/1ps
// dvt_shadow: holds the configuration for the frame in progress.
// Captures the live inputs while reset is held and whenever load is high
// (the last cycle of a frame), pre-computing segment boundaries so that the
// counters only need comparisons. Assumes load comes from the frame wrap.
module dvt_shadow #(
    parameter int HW      = 12,
    parameter int PW      = 10,
    parameter int VW      = 10,
    parameter int VSA_MAX = 15,
    localparam int AW     = PW + 2,
    localparam int SW     = ((HW > AW) ? HW : AW) + 2,
    localparam int VSW    = VW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [HW-1:0]  in_hsa,
    input  logic [HW-1:0]  in_hbp,
    input  logic [HW-1:0]  in_hline,
    input  logic [AW-1:0]  in_act,
    input  logic [VW-1:0]  in_vsa,
    input  logic [VW-1:0]  in_vbp,
    input  logic [VW-1:0]  in_vact,
    input  logic [VW-1:0]  in_vfp,
    input  logic [2:1]     in_pol,
    input  logic [1:0]     in_mode,
    output logic [SW-1:0]  h_b1,
    output logic [SW-1:0]  h_b2,
    output logic [SW-1:0]  h_b3,
    output logic [SW-1:0]  h_last,
    output logic           h_err,
    output logic [VSW-1:0] v_b1,
    output logic [VSW-1:0] v_b2,
    output logic [VSW-1:0] v_b3,
    output logic [VSW-1:0] v_last,
    output logic [2:1]     pol,
    output logic [1:0]     mode
);
    logic [SW-1:0]  n_b1, n_b2, n_b3, n_len;
    logic           n_err;
    logic [VSW-1:0] n_vsa, n_v2, n_v3, n_vlen;

    // Horizontal boundaries; front porch is whatever the line time leaves.
    always_comb begin
        n_b1  = SW'(in_hsa);
        n_b2  = n_b1 + SW'(in_hbp);
        n_b3  = n_b2 + SW'(in_act);
        n_err = (SW'(in_hline) < n_b3);
        n_len = n_err ? n_b3 : SW'(in_hline);
        if (n_len == '0) n_len = SW'(1);
    end

    // Vertical boundaries with the sync line count capped.
    always_comb begin
        n_vsa  = (VSW'(in_vsa) > VSW'(VSA_MAX)) ? VSW'(VSA_MAX) : VSW'(in_vsa);
        n_v2   = n_vsa + VSW'(in_vbp);
        n_v3   = n_v2 + VSW'(in_vact);
        n_vlen = n_v3 + VSW'(in_vfp);
        if (n_vlen == '0) n_vlen = VSW'(1);
    end

    // Capture register: follows the inputs in reset, then only at frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            h_b1   <= n_b1;
            h_b2   <= n_b2;
            h_b3   <= n_b3;
            h_last <= n_len - SW'(1);
            h_err  <= n_err;
            v_b1   <= n_vsa;
            v_b2   <= n_v2;
            v_b3   <= n_v3;
            v_last <= n_vlen - VSW'(1);
            pol    <= in_pol;
            mode   <= in_mode;
        end
    end

    // R11: held configuration changes only on a frame-boundary load.
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(h_last) && $stable(h_b3) && $stable(v_last)
                   && $stable(v_b1) && $stable(pol) && $stable(mode)));
endmodule

// File: rtl/dvt_seg_ctr.sv
`timescale 1ns/1ps
// dvt_seg_ctr: wrapping position counter with four-segment decode.
// Counts when adv is high, returns to zero after reaching last, and reports
// which segment the position lies in given ascending boundaries b1<=b2<=b3.
// Assumes last only changes in the cycle the counter wraps.
module dvt_seg_ctr #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [W-1:0]  last,
    input  logic [W-1:0]  b1,
    input  logic [W-1:0]  b2,
    input  logic [W-1:0]  b3,
    output logic [W-1:0]  cnt,
    output dvt_pkg::seg_e seg,
    output logic          at_last
);
    assign at_last = (cnt == last);

    // Position register with wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (adv)
            cnt <= at_last ? '0 : cnt + W'(1);
    end

    // Segment decode from the position and the boundaries.
    always_comb begin
        if (cnt < b1)
            seg = dvt_pkg::SEG_SYNC;
        else if (cnt < b2)
            seg = dvt_pkg::SEG_BACK;
        else if (cnt < b3)
            seg = dvt_pkg::SEG_ACT;
        else
            seg = dvt_pkg::SEG_FRONT;
    end

    // R4/R5: the position never exceeds the programmed length.
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);
endmodule

// File: rtl/dsi_vid_timing.sv
`timescale 1ns/1ps
// dsi_vid_timing: DSI video-mode frame timing generator.
// One cycle is one lane byte clock. Horizontal segments are in byte clocks,
// the active width derives from the packet size at 3 bytes per pixel, and
// vertical segments are in lines. Configuration is captured in reset and at
// each frame boundary. Assumes the consumer samples the flags every cycle.
module dsi_vid_timing #(
    parameter int HW      = 12,
    parameter int PW      = 10,
    parameter int VW      = 10,
    parameter int VSA_MAX = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] cfg_hsa,
    input  logic [HW-1:0] cfg_hbp,
    input  logic [HW-1:0] cfg_hline,
    input  logic [PW-1:0] cfg_pkt,
    input  logic [2:0]    cfg_lanes,
    input  logic [VW-1:0] cfg_vsa,
    input  logic [VW-1:0] cfg_vbp,
    input  logic [VW-1:0] cfg_vact,
    input  logic [VW-1:0] cfg_vfp,
    input  logic [2:1]    cfg_pol,
    input  logic [1:0]    cfg_mode,
    output logic          hsync,
    output logic          hbp,
    output logic          hact,
    output logic          hfp,
    output logic          vsync,
    output logic          vbp,
    output logic          vact,
    output logic          vfp,
    output logic          hsync_pin,
    output logic          vsync_pin,
    output logic          line_start,
    output logic          frame_start,
    output logic          pkt_req,
    output logic          hs_start,
    output logic          hs_end,
    output logic          vs_start,
    output logic          vs_end,
    output logic          line_err
);
    localparam int AW  = PW + 2;
    localparam int SW  = ((HW > AW) ? HW : AW) + 2;
    localparam int VSW = VW + 2;

    logic [AW-1:0]  act_len;
    logic [SW-1:0]  h_b1, h_b2, h_b3, h_last, h_cnt;
    logic [VSW-1:0] v_b1, v_b2, v_b3, v_last, v_cnt;
    logic [2:1]     pol_q;
    logic [1:0]     mode_q;
    logic           h_at_last, v_at_last, frame_wrap, events_mode;
    dvt_pkg::seg_e  h_seg, v_seg;

    dvt_act_len #(.PW(PW), .AW(AW)) u_act (
        .pkt   (cfg_pkt),
        .lanes (cfg_lanes),
        .act   (act_len)
    );

    dvt_shadow #(.HW(HW), .PW(PW), .VW(VW), .VSA_MAX(VSA_MAX)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_wrap),
        .in_hsa   (cfg_hsa),
        .in_hbp   (cfg_hbp),
        .in_hline (cfg_hline),
        .in_act   (act_len),
        .in_vsa   (cfg_vsa),
        .in_vbp   (cfg_vbp),
        .in_vact  (cfg_vact),
        .in_vfp   (cfg_vfp),
        .in_pol   (cfg_pol),
        .in_mode  (cfg_mode),
        .h_b1     (h_b1),
        .h_b2     (h_b2),
        .h_b3     (h_b3),
        .h_last   (h_last),
        .h_err    (line_err),
        .v_b1     (v_b1),
        .v_b2     (v_b2),
        .v_b3     (v_b3),
        .v_last   (v_last),
        .pol      (pol_q),
        .mode     (mode_q)
    );

    dvt_seg_ctr #(.W(SW)) u_hctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (1'b1),
        .last    (h_last),
        .b1      (h_b1),
        .b2      (h_b2),
        .b3      (h_b3),
        .cnt     (h_cnt),
        .seg     (h_seg),
        .at_last (h_at_last)
    );

    dvt_seg_ctr #(.W(VSW)) u_vctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (h_at_last),
        .last    (v_last),
        .b1      (v_b1),
        .b2      (v_b2),
        .b3      (v_b3),
        .cnt     (v_cnt),
        .seg     (v_seg),
        .at_last (v_at_last)
    );

    assign frame_wrap  = h_at_last && v_at_last;
    assign events_mode = (mode_q == dvt_pkg::MODE_SYNC_EVENTS);

    // Segment flags from both counters.
    always_comb begin
        hsync = (h_seg == dvt_pkg::SEG_SYNC);
        hbp   = (h_seg == dvt_pkg::SEG_BACK);
        hact  = (h_seg == dvt_pkg::SEG_ACT);
        hfp   = (h_seg == dvt_pkg::SEG_FRONT);
        vsync = (v_seg == dvt_pkg::SEG_SYNC);
        vbp   = (v_seg == dvt_pkg::SEG_BACK);
        vact  = (v_seg == dvt_pkg::SEG_ACT);
        vfp   = (v_seg == dvt_pkg::SEG_FRONT);
    end

    // Strobes, sync edge markers and polarity-adjusted sync levels.
    always_comb begin
        line_start  = (h_cnt == '0);
        frame_start = line_start && (v_cnt == '0);
        pkt_req     = hact && vact && (h_cnt == h_b2);
        hs_start    = hsync && line_start;
        vs_start    = vsync && frame_start;
        hs_end      = hsync && !events_mode && ((h_cnt + SW'(1)) == h_b1);
        vs_end      = vsync && !events_mode && h_at_last
                      && ((v_cnt + VSW'(1)) == v_b1);
        hsync_pin   = hsync ^ pol_q[2];
        vsync_pin   = vsync ^ pol_q[1];
    end

    // R8: a packet is only requested inside both active regions.
    p_pkt_in_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req |-> (hact && vact));

    // R4: a too-short line has no front porch.
    p_no_front_on_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |-> !hfp);

    // R6: sync lines stay below the cap.
    p_vsync_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> (v_cnt < VSW'(VSA_MAX)));

    // R5: vertical flags only move at a line start.
    p_vseg_line_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |-> $stable({vsync, vbp, vact, vfp}));

    // R10: after the last sync cycle the line leaves sync or restarts.
    p_hs_end_leaves_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hs_end |=> (!hsync || line_start));
endmodule

// File: tb/tb_dsi_vid_timing.sv
`timescale 1ns/1ps
// Self-checking sweep bench for dsi_vid_timing with an arithmetic model.
module tb_dsi_vid_timing;
    localparam int HW = 12;
    localparam int PW = 10;
    localparam int VW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HW-1:0] cfg_hsa, cfg_hbp, cfg_hline;
    logic [PW-1:0] cfg_pkt;
    logic [2:0]    cfg_lanes;
    logic [VW-1:0] cfg_vsa, cfg_vbp, cfg_vact, cfg_vfp;
    logic [2:1]    cfg_pol;
    logic [1:0]    cfg_mode;
    logic hsync, hbp, hact, hfp, vsync, vbp, vact, vfp;
    logic hsync_pin, vsync_pin, line_start, frame_start, pkt_req;
    logic hs_start, hs_end, vs_start, vs_end, line_err;

    dsi_vid_timing #(.HW(HW), .PW(PW), .VW(VW), .VSA_MAX(15)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hline(cfg_hline),
        .cfg_pkt(cfg_pkt), .cfg_lanes(cfg_lanes),
        .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
        .cfg_pol(cfg_pol), .cfg_mode(cfg_mode),
        .hsync(hsync), .hbp(hbp), .hact(hact), .hfp(hfp),
        .vsync(vsync), .vbp(vbp), .vact(vact), .vfp(vfp),
        .hsync_pin(hsync_pin), .vsync_pin(vsync_pin),
        .line_start(line_start), .frame_start(frame_start), .pkt_req(pkt_req),
        .hs_start(hs_start), .hs_end(hs_end), .vs_start(vs_start), .vs_end(vs_end),
        .line_err(line_err)
    );

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit old_frame = 1'b0;
    int wraps = 0;
    int m_hc = 0, m_vc = 0;
    int s_hsa, s_hbp, s_hline, s_pkt, s_lanes, s_vsa, s_vbp, s_vact, s_vfp, s_pol, s_mode;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (hc=%0d vc=%0d)", tag, act, exp, m_hc, m_vc);
        end
    endtask

    task automatic set_cfg(input int hsa, hbp, hline, pkt, lanes, vsa, vbp, vact, vfp, pol, mode);
        cfg_hsa = HW'(hsa); cfg_hbp = HW'(hbp); cfg_hline = HW'(hline);
        cfg_pkt = PW'(pkt); cfg_lanes = 3'(lanes);
        cfg_vsa = VW'(vsa); cfg_vbp = VW'(vbp); cfg_vact = VW'(vact); cfg_vfp = VW'(vfp);
        cfg_pol = 2'(pol >> 1); cfg_mode = 2'(mode);
    endtask

    task automatic load_model();
        s_hsa = int'(cfg_hsa); s_hbp = int'(cfg_hbp); s_hline = int'(cfg_hline);
        s_pkt = int'(cfg_pkt); s_lanes = int'(cfg_lanes);
        s_vsa = int'(cfg_vsa); s_vbp = int'(cfg_vbp); s_vact = int'(cfg_vact); s_vfp = int'(cfg_vfp);
        s_pol = int'(cfg_pol) << 1; s_mode = int'(cfg_mode);
    endtask

    function automatic int a_len();
        int ln = (s_lanes < 1) ? 1 : ((s_lanes > 4) ? 4 : s_lanes);
        return (3 * s_pkt + ln - 1) / ln;
    endfunction
    function automatic int h_sum();
        return s_hsa + s_hbp + a_len();
    endfunction
    function automatic int line_len();
        int l = (s_hline > h_sum()) ? s_hline : h_sum();
        return (l < 1) ? 1 : l;
    endfunction
    function automatic int vsa_c();
        return (s_vsa > 15) ? 15 : s_vsa;
    endfunction
    function automatic int frame_len();
        int f = vsa_c() + s_vbp + s_vact + s_vfp;
        return (f < 1) ? 1 : f;
    endfunction

    task automatic check_cycle();
        string pre = old_frame ? "R11 old-config " : "";
        int hr, vr, L;
        bit e_hs, e_vs, ev;
        L = line_len();
        hr = (m_hc < s_hsa) ? 0 : (m_hc < s_hsa + s_hbp) ? 1 : (m_hc < h_sum()) ? 2 : 3;
        vr = (m_vc < vsa_c()) ? 0 : (m_vc < vsa_c() + s_vbp) ? 1 :
             (m_vc < vsa_c() + s_vbp + s_vact) ? 2 : 3;
        e_hs = (hr == 0);
        e_vs = (vr == 0);
        ev = (s_mode != 1);
        chk({pre, "R2 hsync/hbp"}, {hsync, hbp}, {e_hs, hr == 1});
        chk({pre, "R3 hact length"}, hact, hr == 2);
        chk({pre, "R4 hfp/line_err"}, {hfp, line_err}, {hr == 3, s_hline < h_sum()});
        chk({pre, "R5 vbp/vact/vfp"}, {vbp, vact, vfp}, {vr == 1, vr == 2, vr == 3});
        chk({pre, "R6 vsync clamp"}, vsync, e_vs);
        chk({pre, "R7 sync pins"}, {hsync_pin, vsync_pin},
            {e_hs ^ s_pol[2], e_vs ^ s_pol[1]});
        chk({pre, "R8 line/frame/pkt strobes"}, {line_start, frame_start, pkt_req},
            {m_hc == 0, m_hc == 0 && m_vc == 0,
             hr == 2 && vr == 2 && m_hc == s_hsa + s_hbp});
        chk({pre, "R9 sync start"}, {hs_start, vs_start},
            {e_hs && m_hc == 0, e_vs && m_hc == 0 && m_vc == 0});
        chk({pre, "R10 sync end"}, {hs_end, vs_end},
            {ev && e_hs && m_hc == s_hsa - 1,
             ev && e_vs && m_vc == vsa_c() - 1 && m_hc == L - 1});
    endtask

    task automatic advance();
        if (m_hc == line_len() - 1) begin
            m_hc = 0;
            if (m_vc == frame_len() - 1) begin
                m_vc = 0;
                load_model();
                wraps++;
            end else begin
                m_vc++;
            end
        end else begin
            m_hc++;
        end
    endtask

    task automatic step();
        check_cycle();
        advance();
        @(negedge clk);
    endtask

    initial begin
        set_cfg(2, 1, 12, 2, 2, 2, 1, 2, 1, 4, 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset line/frame start", {line_start, frame_start}, 3);
        rst_n = 1'b1;
        load_model();
        m_hc = 0; m_vc = 0;
        chk("R1 first cycle after reset", {line_start, frame_start, vsync}, 7);
        for (int k = 0; k < 2; k++) begin
            int w = wraps;
            while (wraps == w) step();
        end
        for (int ln = 0; ln < 6; ln++)
            for (int pi = 0; pi < 2; pi++)
                for (int hi = 0; hi < 2; hi++)
                    for (int md = 0; md < 4; md++) begin
                        int vs, w;
                        vs = (md == 0) ? 0 : (md == 1) ? 3 : (md == 2) ? 20 : 1;
                        set_cfg((md == 2) ? 0 : 2, 1, (hi == 0) ? 4 : 30,
                                (pi == 0) ? 1 : 7, ln, vs, 1, 2,
                                (md == 3) ? 0 : 1, md << 1, md);
                        old_frame = 1'b1;
                        w = wraps;
                        while (wraps == w) step();
                        old_frame = 1'b0;
                        w = wraps;
                        while (wraps == w) step();
                    end
        // Reset in the middle of a frame restarts at a frame start (R1).
        repeat (7) step();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-frame reset", {line_start, frame_start}, 3);
        rst_n = 1'b1;
        load_model();
        m_hc = 0; m_vc = 0;
        repeat (40) step();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule